// File: doc/BRIEF.md
# Register window bridge to a byte-port bank and an indexed register file

The block exposes a 4096-byte memory-mapped window on a simple bus slave. Two areas inside the window are live. The first is a 32-byte span at offset 0x400 that maps byte for byte onto a legacy port bank. Its port number is 0x3C0 plus the offset into the span. The second is an eleven-entry, 16-bit register file at offset 0x500. That file is reached through an index register and a data register. Every other offset reads as zero and drops writes.

A bus access of one to four bytes is split into a sequence of downstream strobes. Legacy accesses go out one byte per cycle in ascending address order, with the low byte first. This lets one word write program an index/data port pair. Extension accesses go out in 16-bit pieces. Each piece is an index write followed by a data access. The bus sees `ready_o` low until the whole sequence has finished. Read data is assembled little-endian.

Top module: `regwin_bridge`

## Requirements
- R1: While `en_i` is low, every access finishes without `ready_o` falling. It issues no downstream strobe, and a read returns zero.
- R2: A window offset of 0x400 + k (k from 0 to 31) reaches the legacy bank at `lp_addr_o` = k, which is port 0x3C0 + k.
- R3: A legacy write of n bytes (`size_i` = n-1) issues n byte writes at offsets N, N+1, and so on, in that order. Byte k of `wdata_i` goes to N+k.
- R4: A legacy read of n bytes returns the byte at N+k in bits 8k+7:8k of `rdata_o`.
- R5: The extension area covers offsets 0x500 to 0x515. The register index is (offset - 0x500) >> 1. A 1- or 2-byte access is one 16-bit piece. A 3- or 4-byte access is two pieces, at the index and at the index plus one. Piece p carries bits 16p+15:16p.
- R6: Each extension piece takes two cycles. The first writes the index (on `ex_wdata_o`, with `ex_idx_wr_o`). The second reads or writes the data register.
- R7: An access that starts outside both areas issues no strobe and reads zero. A legacy byte beyond offset 0x41F issues no strobe and reads zero, and so does an extension piece whose index is 11 or more.
- R8: `ready_o` is high when idle. An access is accepted when `req_i` and `ready_o` are both high. After that, `ready_o` stays low for n cycles on a legacy access and 2 cycles per piece on an extension access. It does not fall for an access outside both areas.
- R9: Every downstream strobe is one cycle long, and at most one strobe is high in any cycle.
- R10: Bytes of `rdata_o` above the access size read zero, and a write leaves `rdata_o` at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Window enable, normally tied high |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte offset in the window |
| size_i | input | 2 | Byte count minus one |
| wdata_i | input | 32 | Write data, little-endian |
| ready_o | output | 1 | Idle / access complete |
| rdata_o | output | 32 | Read data, valid while ready_o is high |
| lp_addr_o | output | 5 | Legacy port offset from 0x3C0 |
| lp_wr_o | output | 1 | Legacy byte write strobe |
| lp_rd_o | output | 1 | Legacy byte read strobe |
| lp_wdata_o | output | 8 | Legacy write byte |
| lp_rdata_i | input | 8 | Legacy read byte, same cycle as lp_rd_o |
| ex_idx_wr_o | output | 1 | Extension index write strobe |
| ex_data_wr_o | output | 1 | Extension data write strobe |
| ex_data_rd_o | output | 1 | Extension data read strobe |
| ex_wdata_o | output | 16 | Index value or data word |
| ex_rdata_i | input | 16 | Extension read word, same cycle as ex_data_rd_o |

## Verification
The bench runs accesses of every size against both areas, at the start, middle and end of each area, with simple bank models behind the ports. Unaligned and edge-straddling accesses separate correct per-byte range checks from whole-access decoding. Word writes into the legacy bank are logged to show that the low byte goes out first. Extension writes are logged to show the index-then-data order, and reads through the model catch a missing or late index. Accesses with the window disabled and accesses to unmapped offsets show that writes are dropped and that reads return zero without a stall.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  localparam int ADDR_W   = 12;
  localparam int DATA_W   = 32;
  localparam int EWORD_W  = 16;
  localparam int LEG_BASE = 'h400;
  localparam int LEG_SPAN = 32;
  localparam int EXT_BASE = 'h500;
  localparam int EXT_REGS = 11;

  typedef enum logic [1:0] {RGN_NONE, RGN_LEG, RGN_EXT} rgn_e;
endpackage

// File: rtl/regwin_decode.sv
module regwin_decode
  import regwin_pkg::*;
#(
  parameter int LBASE = LEG_BASE,
  parameter int LSPAN = LEG_SPAN,
  parameter int EBASE = EXT_BASE,
  parameter int EREGS = EXT_REGS
) (
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output rgn_e              rgn_o
);
  int a;
  always_comb begin
    a = int'(addr_i);
    rgn_o = RGN_NONE;
    if (en_i) begin
      if (a >= LBASE && a < LBASE + LSPAN) rgn_o = RGN_LEG;
      else if (a >= EBASE && a < EBASE + 2 * EREGS) rgn_o = RGN_EXT;
    end
  end
endmodule

// File: rtl/regwin_leg_seq.sv
module regwin_leg_seq
  import regwin_pkg::*;
#(
  parameter int LBASE  = LEG_BASE,
  parameter int LSPAN  = LEG_SPAN,
  parameter int PORT_W = $clog2(LSPAN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        last_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              busy_o,
  output logic [PORT_W-1:0] lp_addr_o,
  output logic              lp_wr_o,
  output logic              lp_rd_o,
  output logic [7:0]        lp_wdata_o,
  input  logic [7:0]        lp_rdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic              busy_q, we_q;
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        k_q, last_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [ADDR_W:0]   cur;
  logic              in_rng;

  always_comb begin
    cur        = {1'b0, base_q} + {{(ADDR_W - 1){1'b0}}, k_q};
    in_rng     = int'(cur) < LBASE + LSPAN;
    lp_addr_o  = PORT_W'(int'(cur) - LBASE);
    lp_wr_o    = busy_q & in_rng & we_q;
    lp_rd_o    = busy_q & in_rng & ~we_q;
    lp_wdata_o = wdata_q[{k_q, 3'b000} +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      we_q    <= 1'b0;
      base_q  <= '0;
      k_q     <= '0;
      last_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else if (start_i) begin
      busy_q  <= 1'b1;
      we_q    <= we_i;
      base_q  <= addr_i;
      k_q     <= '0;
      last_q  <= last_i;
      wdata_q <= wdata_i;
      rdata_q <= '0;
    end else if (busy_q) begin
      if (lp_rd_o) rdata_q[{k_q, 3'b000} +: 8] <= lp_rdata_i;
      if (k_q == last_q) busy_q <= 1'b0;
      else               k_q    <= k_q + 2'd1;
    end
  end

  assign busy_o  = busy_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/regwin_ext_seq.sv
module regwin_ext_seq
  import regwin_pkg::*;
#(
  parameter int EBASE = EXT_BASE,
  parameter int EREGS = EXT_REGS,
  parameter int IDX_W = $clog2(EREGS) + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               two_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic               busy_o,
  output logic               ex_idx_wr_o,
  output logic               ex_data_wr_o,
  output logic               ex_data_rd_o,
  output logic [EWORD_W-1:0] ex_wdata_o,
  input  logic [EWORD_W-1:0] ex_rdata_i,
  output logic [DATA_W-1:0]  rdata_o
);
  logic              busy_q, phase_q, p_q, two_q, we_q;
  logic [IDX_W-1:0]  idx0_q, idx_cur;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              valid;

  always_comb begin
    idx_cur      = idx0_q + IDX_W'(p_q);
    valid        = int'(idx_cur) < EREGS;
    ex_idx_wr_o  = busy_q & ~phase_q & valid;
    ex_data_wr_o = busy_q & phase_q & valid & we_q;
    ex_data_rd_o = busy_q & phase_q & valid & ~we_q;
    if (!phase_q)  ex_wdata_o = EWORD_W'(idx_cur);
    else if (we_q) ex_wdata_o = wdata_q[{p_q, 4'b0000} +: EWORD_W];
    else           ex_wdata_o = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      p_q     <= 1'b0;
      two_q   <= 1'b0;
      we_q    <= 1'b0;
      idx0_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else if (start_i) begin
      busy_q  <= 1'b1;
      phase_q <= 1'b0;
      p_q     <= 1'b0;
      two_q   <= two_i;
      we_q    <= we_i;
      idx0_q  <= IDX_W'((int'(addr_i) - EBASE) >> 1);
      wdata_q <= wdata_i;
      rdata_q <= '0;
    end else if (busy_q) begin
      if (!phase_q) begin
        phase_q <= 1'b1;
      end else begin
        phase_q <= 1'b0;
        if (ex_data_rd_o) rdata_q[{p_q, 4'b0000} +: EWORD_W] <= ex_rdata_i;
        if (p_q == two_q) busy_q <= 1'b0;
        else              p_q    <= 1'b1;
      end
    end
  end

  assign busy_o  = busy_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/regwin_bridge.sv
module regwin_bridge
  import regwin_pkg::*;
#(
  parameter int LBASE  = LEG_BASE,
  parameter int LSPAN  = LEG_SPAN,
  parameter int EBASE  = EXT_BASE,
  parameter int EREGS  = EXT_REGS,
  localparam int PORT_W = $clog2(LSPAN)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [1:0]         size_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic               ready_o,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [PORT_W-1:0]  lp_addr_o,
  output logic               lp_wr_o,
  output logic               lp_rd_o,
  output logic [7:0]         lp_wdata_o,
  input  logic [7:0]         lp_rdata_i,
  output logic               ex_idx_wr_o,
  output logic               ex_data_wr_o,
  output logic               ex_data_rd_o,
  output logic [EWORD_W-1:0] ex_wdata_o,
  input  logic [EWORD_W-1:0] ex_rdata_i
);
  rgn_e              rgn, rgn_q;
  logic [1:0]        size_q;
  logic              accept, leg_busy, ext_busy;
  logic [DATA_W-1:0] leg_rdata, ext_rdata, raw, mask;

  regwin_decode #(.LBASE(LBASE), .LSPAN(LSPAN), .EBASE(EBASE), .EREGS(EREGS)) u_dec (
    .en_i(en_i), .addr_i(addr_i), .rgn_o(rgn)
  );

  assign ready_o = ~(leg_busy | ext_busy);
  assign accept  = req_i & ready_o;

  regwin_leg_seq #(.LBASE(LBASE), .LSPAN(LSPAN), .PORT_W(PORT_W)) u_leg (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_i(accept && rgn == RGN_LEG), .we_i(we_i), .addr_i(addr_i),
    .last_i(size_i), .wdata_i(wdata_i), .busy_o(leg_busy),
    .lp_addr_o(lp_addr_o), .lp_wr_o(lp_wr_o), .lp_rd_o(lp_rd_o),
    .lp_wdata_o(lp_wdata_o), .lp_rdata_i(lp_rdata_i), .rdata_o(leg_rdata)
  );

  regwin_ext_seq #(.EBASE(EBASE), .EREGS(EREGS)) u_ext (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_i(accept && rgn == RGN_EXT), .we_i(we_i), .addr_i(addr_i),
    .two_i(size_i[1]), .wdata_i(wdata_i), .busy_o(ext_busy),
    .ex_idx_wr_o(ex_idx_wr_o), .ex_data_wr_o(ex_data_wr_o),
    .ex_data_rd_o(ex_data_rd_o), .ex_wdata_o(ex_wdata_o),
    .ex_rdata_i(ex_rdata_i), .rdata_o(ext_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rgn_q  <= RGN_NONE;
      size_q <= '0;
    end else if (accept) begin
      rgn_q  <= rgn;
      size_q <= size_i;
    end
  end

  always_comb begin
    case (rgn_q)
      RGN_LEG: raw = leg_rdata;
      RGN_EXT: raw = ext_rdata;
      default: raw = '0;
    endcase
    for (int b = 0; b < DATA_W / 8; b++)
      mask[8*b +: 8] = (b <= int'(size_q)) ? 8'hFF : 8'h00;
    rdata_o = raw & mask;
  end
endmodule

// File: rtl/regwin_checker.sv
module regwin_checker
  import regwin_pkg::*;
#(
  parameter int EREGS = EXT_REGS
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               en_i,
  input logic               req_i,
  input logic               we_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [1:0]         size_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic               ready_o,
  input logic [DATA_W-1:0]  rdata_o,
  input logic [4:0]         lp_addr_o,
  input logic               lp_wr_o,
  input logic               lp_rd_o,
  input logic [7:0]         lp_wdata_o,
  input logic [7:0]         lp_rdata_i,
  input logic               ex_idx_wr_o,
  input logic               ex_data_wr_o,
  input logic               ex_data_rd_o,
  input logic [EWORD_W-1:0] ex_wdata_o,
  input logic [EWORD_W-1:0] ex_rdata_i
);
  logic [4:0] stb;
  assign stb = {lp_wr_o, lp_rd_o, ex_idx_wr_o, ex_data_wr_o, ex_data_rd_o};

  p_one_strobe_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(stb) <= 1);

  p_strobe_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb != 5'd0) |-> !ready_o);

  p_disabled_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o && !en_i) |=> (ready_o && stb == 5'd0));

  p_data_after_idx_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ex_idx_wr_o |=> (ex_data_wr_o || ex_data_rd_o));

  p_idx_before_data_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_data_wr_o || ex_data_rd_o) |-> $past(ex_idx_wr_o));

  p_idx_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ex_idx_wr_o |-> (int'(ex_wdata_o) < EREGS));

  p_write_no_rdata_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o && we_i) |=> (rdata_o == '0));
endmodule

bind regwin_bridge regwin_checker #(.EREGS(EREGS)) u_chk (.*);

// File: tb/regwin_bridge_test.sv
`timescale 1ns/1ps
module regwin_bridge_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        en = 1'b1, req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [1:0]  size = '0;
  logic [31:0] wdata = '0;
  logic        ready;
  logic [31:0] rdata;
  logic [4:0]  lp_addr;
  logic        lp_wr, lp_rd;
  logic [7:0]  lp_wdata, lp_rdata;
  logic        ex_iw, ex_dw, ex_dr;
  logic [15:0] ex_wdata, ex_rdata;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  regwin_bridge uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .req_i(req), .we_i(we),
    .addr_i(addr), .size_i(size), .wdata_i(wdata), .ready_o(ready), .rdata_o(rdata),
    .lp_addr_o(lp_addr), .lp_wr_o(lp_wr), .lp_rd_o(lp_rd), .lp_wdata_o(lp_wdata),
    .lp_rdata_i(lp_rdata), .ex_idx_wr_o(ex_iw), .ex_data_wr_o(ex_dw),
    .ex_data_rd_o(ex_dr), .ex_wdata_o(ex_wdata), .ex_rdata_i(ex_rdata)
  );

  // downstream models and event log
  logic [7:0]  leg_mem [32];
  logic [15:0] ext_mem [16];
  logic [3:0]  ext_idx;
  int          ev_kind [16];
  int          ev_addr [16];
  int          ev_data [16];
  int          ev_n = 0, stb_cnt = 0, multi_cnt = 0;

  assign lp_rdata = leg_mem[lp_addr];
  assign ex_rdata = ext_mem[ext_idx];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) leg_mem[i] <= '0;
      for (int i = 0; i < 16; i++) ext_mem[i] <= '0;
      ext_idx <= '0;
    end else begin
      if (lp_wr) leg_mem[lp_addr] <= lp_wdata;
      if (ex_iw) ext_idx <= ex_wdata[3:0];
      if (ex_dw) ext_mem[ext_idx] <= ex_wdata;
    end
  end

  always @(posedge clk) begin
    if (rst_n) begin
      int n;
      n = int'(lp_wr) + int'(lp_rd) + int'(ex_iw) + int'(ex_dw) + int'(ex_dr);
      stb_cnt = stb_cnt + n;
      if (n > 1) multi_cnt = multi_cnt + 1;
      if (n > 0 && ev_n < 16) begin
        ev_kind[ev_n] = lp_wr ? 1 : lp_rd ? 2 : ex_iw ? 3 : ex_dw ? 4 : 5;
        ev_addr[ev_n] = int'(lp_addr);
        ev_data[ev_n] = (lp_wr || lp_rd) ? int'(lp_wdata) : int'(ex_wdata);
        ev_n = ev_n + 1;
      end
    end
  end

  task automatic chk(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [11:0] a, input logic [1:0] s,
                        input logic [31:0] d, output logic [31:0] r, output int cyc);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; size = s; wdata = d;
    @(negedge clk);
    req = 1'b0;
    cyc = 0;
    while (!ready && cyc < 50) begin
      cyc++;
      @(negedge clk);
    end
    r = rdata;
  endtask

  typedef struct packed {
    logic        we;
    logic [11:0] addr;
    logic [1:0]  sz;
    logic [31:0] wd;
    logic [31:0] exp;
    logic [7:0]  tag;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 12'h400, 2'd1, 32'h0000BBAA, 32'h0, 8'd3},
    '{1'b0, 12'h400, 2'd1, 32'h0,        32'h0000BBAA, 8'd4},
    '{1'b1, 12'h41C, 2'd3, 32'h44332211, 32'h0, 8'd3},
    '{1'b0, 12'h41D, 2'd1, 32'h0,        32'h00003322, 8'd4},
    '{1'b0, 12'h41E, 2'd3, 32'h0,        32'h00004433, 8'd7},
    '{1'b1, 12'h500, 2'd3, 32'h56781234, 32'h0, 8'd5},
    '{1'b0, 12'h502, 2'd1, 32'h0,        32'h00005678, 8'd5},
    '{1'b0, 12'h500, 2'd3, 32'h0,        32'h56781234, 8'd5},
    '{1'b1, 12'h514, 2'd3, 32'hDEADBEEF, 32'h0, 8'd7},
    '{1'b0, 12'h514, 2'd3, 32'h0,        32'h0000BEEF, 8'd7},
    '{1'b0, 12'h600, 2'd3, 32'h0,        32'h0, 8'd7},
    '{1'b1, 12'h300, 2'd3, 32'hFFFFFFFF, 32'h0, 8'd7},
    '{1'b0, 12'h400, 2'd0, 32'h0,        32'h000000AA, 8'd10},
    '{1'b0, 12'h501, 2'd0, 32'h0,        32'h00000034, 8'd10},
    '{1'b1, 12'h401, 2'd0, 32'h00000077, 32'h0, 8'd3},
    '{1'b0, 12'h400, 2'd1, 32'h0,        32'h000077AA, 8'd4},
    '{1'b0, 12'h41F, 2'd2, 32'h0,        32'h00000044, 8'd7}
  };

  initial begin
    logic [31:0] r;
    int cyc, s0;
    repeat (3) @(negedge clk);
    // R8 R10 R9: reset state
    chk("R8 reset ready", {31'b0, ready}, 32'd1);
    chk("R10 reset rdata", rdata, 32'h0);
    chk("R9 reset strobes", {27'b0, lp_wr, lp_rd, ex_iw, ex_dw, ex_dr}, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      access(TBL[i].we, TBL[i].addr, TBL[i].sz, TBL[i].wd, r, cyc);
      chk($sformatf("R%0d vector %0d", TBL[i].tag, i), r, TBL[i].exp);
    end

    // R2: offset-to-port mapping seen in the bank model
    chk("R2 port 0x3DC", {24'b0, leg_mem[28]}, 32'h11);
    chk("R2 port 0x3DF", {24'b0, leg_mem[31]}, 32'h44);
    chk("R2 port 0x3C1", {24'b0, leg_mem[1]}, 32'h77);
    chk("R5 ext reg 10", {16'b0, ext_mem[10]}, 32'hBEEF);
    chk("R7 ext reg 11 untouched", {16'b0, ext_mem[11]}, 32'h0);

    // R3: byte order of a word write
    ev_n = 0;
    access(1'b1, 12'h410, 2'd1, 32'h00005A3C, r, cyc);
    chk("R3 count", ev_n, 2);
    chk("R3 first addr", ev_addr[0], 32'h10);
    chk("R3 first data", ev_data[0], 32'h3C);
    chk("R3 second addr", ev_addr[1], 32'h11);
    chk("R3 second data", ev_data[1], 32'h5A);
    chk("R8 legacy word cycles", cyc, 2);

    // R6: index then data, ascending pieces
    ev_n = 0;
    access(1'b1, 12'h504, 2'd3, 32'h99998888, r, cyc);
    chk("R6 count", ev_n, 4);
    chk("R6 ev0 kind", ev_kind[0], 3);
    chk("R6 ev0 index", ev_data[0], 2);
    chk("R6 ev1 kind", ev_kind[1], 4);
    chk("R6 ev1 data", ev_data[1], 32'h8888);
    chk("R6 ev2 index", ev_data[2], 3);
    chk("R6 ev3 data", ev_data[3], 32'h9999);
    chk("R8 ext dword cycles", cyc, 4);

    // R7: index 11 piece skipped
    ev_n = 0;
    access(1'b1, 12'h514, 2'd3, 32'h12340000, r, cyc);
    chk("R7 skipped piece strobes", ev_n, 2);
    chk("R7 only index 10", ev_data[0], 10);

    // R8: latency per kind
    access(1'b0, 12'h400, 2'd3, 32'h0, r, cyc);
    chk("R8 legacy dword cycles", cyc, 4);
    chk("R4 dword read", r, 32'h000077AA);
    access(1'b0, 12'h506, 2'd1, 32'h0, r, cyc);
    chk("R8 ext word cycles", cyc, 2);
    chk("R5 read index 3", r, 32'h9999);
    access(1'b0, 12'h800, 2'd1, 32'h0, r, cyc);
    chk("R8 unmapped cycles", cyc, 0);

    // R1: disabled window
    en = 1'b0;
    s0 = stb_cnt;
    access(1'b1, 12'h400, 2'd1, 32'h00001111, r, cyc);
    chk("R1 disabled write cycles", cyc, 0);
    access(1'b0, 12'h500, 2'd3, 32'h0, r, cyc);
    chk("R1 disabled read zero", r, 32'h0);
    chk("R1 no strobes", stb_cnt - s0, 0);
    en = 1'b1;
    access(1'b0, 12'h400, 2'd1, 32'h0, r, cyc);
    chk("R1 bank unchanged", r, 32'h000077AA);

    chk("R9 overlapping strobes", multi_cnt, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule